// File: doc/BRIEF.md
# Programmable Interrupt Controller Register Core

This block is the register side of an eight-input interrupt controller. Software reaches it through a byte-wide port with two addresses, a command address (`addr_i` = 0) and a data address (`addr_i` = 1). After reset, software must run an initialization sequence. A command word with bit 4 set starts the sequence. Two to four words follow on the data address. The path through the sequence depends on two bits of the first word. Once the sequence is complete, command writes are operation words. Some of them retire in-service interrupts and others choose what a command-address read returns.

Request lines are sampled every clock into the request register. A pending output reports any request that is not masked. A one-cycle acknowledge input moves the lowest-numbered unmasked request into the in-service register. The stored second and fourth initialization words are driven out to downstream logic. Writes that are not legal in the current state change nothing and raise a one-cycle error pulse.

Top module: `pic_reg_core`

## Requirements
- R1: After reset, the request, in-service and mask registers are zero. Both stored-word outputs are zero. The sequencer awaits the first word. Readback is set to the request register, so reads at address 0 and at address 1 both return 0x00.
- R2: In any state, a command write with bit 4 set stores the byte as the first word. The sequencer then expects the second word.
- R3: After the second word is written to the data address, it appears on `base_o`. If bit 1 of the first word is 0, the next state expects the third word. If bit 1 is 1, the next state expects the fourth word when bit 0 is 1, and is ready when bit 0 is 0.
- R4: After the third word, the next state expects the fourth word if bit 0 of the first word is 1, and is ready otherwise. The fourth word appears on `mode_o`, and the state then becomes ready.
- R5: A data-address write loads the mask only while the sequencer awaits the first word or is ready. A read at the data address returns the mask.
- R6: A command write with bit 4 clear, made while the sequencer awaits the first, second, third or fourth word, is flagged as an error. It changes no state.
- R7: When ready, a command write with bits [4:3] = 00 is an end-of-interrupt word. Its fields are bit 7 rotate, bit 6 select-level, bit 5 EOI and bits [2:0] level. Such a word is an error unless EOI is 1 and rotate is 0.
- R8: A specific end-of-interrupt (EOI=1, rotate=0, select-level=1) clears the in-service bit indexed by the level field.
- R9: A non-specific end-of-interrupt (EOI=1, rotate=0, select-level=0) clears only the lowest-numbered set in-service bit.
- R10: When ready, a command write with bits [4:3] = 01 stores the readback select. A command-address read returns the request register when select bits [1:0] = 10, the in-service register when they are 11, and 0x00 otherwise.
- R11: A high request line sets its request bit at the next clock edge. `pend_o` is high when any set request bit is unmasked.
- R12: `ack_i` moves the lowest-numbered unmasked request bit into the in-service register. It clears that request bit unless the line is still high. With nothing pending, `ack_i` has no effect.
- R13: `err_o` is high for exactly the one cycle after the clock edge that took an invalid write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 1 | 0 = command address, 1 = data address |
| wdata_i | input | 8 | Write data |
| irq_i | input | 8 | Request lines |
| ack_i | input | 1 | Service acknowledge |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| pend_o | output | 1 | An unmasked request is pending |
| err_o | output | 1 | Invalid-write pulse |
| base_o | output | 8 | Stored second initialization word |
| mode_o | output | 8 | Stored fourth initialization word |

## Verification
The hardest case to reach is an operation word that lands while the sequencer is midway through initialization. A write like that has to be refused even though the same byte would be legal once the sequencer is ready. The stimulus runs all four initialization paths. In the middle of a sequence it issues command bytes that look like operation words, then confirms that the following data word is still taken as the pending initialization word. End-of-interrupt coverage needs several in-service bits set at once. The stimulus builds this by pulsing two request lines together and acknowledging twice before it retires them.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W2   = 3'd1,
    ST_W3   = 3'd2,
    ST_W4   = 3'd3,
    ST_RDY  = 3'd4
  } seq_state_e;

  localparam logic ADDR_CMD  = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  // command byte fields
  localparam int B_ROT   = 7;
  localparam int B_SL    = 6;
  localparam int B_EOI   = 5;
  localparam int B_INIT  = 4;
  localparam int B_KIND  = 3;
  localparam int B_SNGL  = 1;
  localparam int B_NEED4 = 0;

  localparam logic [1:0] KIND_EOI = 2'b00;
  localparam logic [1:0] KIND_SEL = 2'b01;
  localparam logic [1:0] SEL_IRR  = 2'b10;
  localparam logic [1:0] SEL_ISR  = 2'b11;
  localparam logic [7:0] SEL_RST  = 8'h02;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output seq_state_e    state_o,
  output logic          imr_we_o,
  output logic          eoi_spec_o,
  output logic          eoi_any_o,
  output logic [LW-1:0] level_o,
  output logic [DW-1:0] sel_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] mode_o,
  output logic          bad_o
);
  seq_state_e    state_q, state_d;
  logic [DW-1:0] w1_q, w2_q, w3_q, w4_q, sel_q;
  logic          cmd_wr, dat_wr, is_init, in_rdy, eoi_ok, eoi_cmd, sel_we;
  logic [1:0]    kind;

  assign cmd_wr  = wr_en_i && (addr_i == ADDR_CMD);
  assign dat_wr  = wr_en_i && (addr_i == ADDR_DATA);
  assign is_init = wdata_i[B_INIT];
  assign kind    = wdata_i[B_INIT:B_KIND];
  assign in_rdy  = (state_q == ST_RDY);
  assign eoi_ok  = wdata_i[B_EOI] && !wdata_i[B_ROT];
  assign eoi_cmd = cmd_wr && !is_init && in_rdy && (kind == KIND_EOI) && eoi_ok;
  assign sel_we  = cmd_wr && !is_init && in_rdy && (kind == KIND_SEL);

  assign eoi_spec_o = eoi_cmd && wdata_i[B_SL];
  assign eoi_any_o  = eoi_cmd && !wdata_i[B_SL];
  assign level_o    = wdata_i[LW-1:0];
  assign imr_we_o   = dat_wr && ((state_q == ST_IDLE) || in_rdy);
  assign bad_o      = cmd_wr && !is_init && (!in_rdy || ((kind == KIND_EOI) && !eoi_ok));

  always_comb begin
    state_d = state_q;
    if (cmd_wr && is_init) begin
      state_d = ST_W2;
    end else if (dat_wr) begin
      unique case (state_q)
        ST_W2:   state_d = !w1_q[B_SNGL] ? ST_W3 : (w1_q[B_NEED4] ? ST_W4 : ST_RDY);
        ST_W3:   state_d = w1_q[B_NEED4] ? ST_W4 : ST_RDY;
        ST_W4:   state_d = ST_RDY;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      w1_q    <= '0;
      w2_q    <= '0;
      w3_q    <= '0;
      w4_q    <= '0;
      sel_q   <= DW'(SEL_RST);
    end else begin
      state_q <= state_d;
      if (cmd_wr && is_init)              w1_q  <= wdata_i;
      if (dat_wr && state_q == ST_W2)     w2_q  <= wdata_i;
      if (dat_wr && state_q == ST_W3)     w3_q  <= wdata_i;
      if (dat_wr && state_q == ST_W4)     w4_q  <= wdata_i;
      if (sel_we)                         sel_q <= wdata_i;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
  assign base_o  = w2_q;
  assign mode_o  = w4_q;

  logic unused_w3;
  assign unused_w3 = ^w3_q;
endmodule

// File: rtl/pic_svc_regs.sv
module pic_svc_regs #(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] irq_i,
  input  logic          ack_i,
  input  logic          imr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          eoi_spec_i,
  input  logic          eoi_any_i,
  input  logic [LW-1:0] level_i,
  output logic [DW-1:0] irr_o,
  output logic [DW-1:0] isr_o,
  output logic [DW-1:0] imr_o,
  output logic          pend_o
);
  logic [DW-1:0] irr_q, isr_q, imr_q;
  logic [DW-1:0] pend_vec, pick, set_v, isr_low, lvl_hit, clr_v;

  assign pend_vec = irr_q & ~imr_q;
  assign pick     = pend_vec & (~pend_vec + DW'(1));
  assign set_v    = ack_i ? pick : '0;
  assign isr_low  = isr_q & (~isr_q + DW'(1));

  for (genvar g = 0; g < DW; g++) begin : g_lvl
    assign lvl_hit[g] = (level_i == LW'(g));
  end

  always_comb begin
    clr_v = '0;
    if (eoi_spec_i)     clr_v = lvl_hit;
    else if (eoi_any_i) clr_v = isr_low;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      imr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~set_v) | irq_i;
      isr_q <= (isr_q & ~clr_v) | set_v;
      if (imr_we_i) imr_q <= wdata_i;
    end
  end

  assign irr_o  = irr_q;
  assign isr_o  = isr_q;
  assign imr_o  = imr_q;
  assign pend_o = |pend_vec;
endmodule

// File: rtl/pic_rdback.sv
module pic_rdback
  import pic_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          addr_i,
  input  logic [DW-1:0] sel_i,
  input  logic [DW-1:0] irr_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] imr_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_DATA) begin
      rdata_o = imr_i;
    end else begin
      unique case (sel_i[1:0])
        SEL_IRR: rdata_o = irr_i;
        SEL_ISR: rdata_o = isr_i;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pic_reg_core.sv
module pic_reg_core
  import pic_pkg::*;
#(
  parameter int DW = 8,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] irq_i,
  input  logic          ack_i,
  output logic [DW-1:0] rdata_o,
  output logic          pend_o,
  output logic          err_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] mode_o
);
  seq_state_e    state;
  logic          imr_we, eoi_spec, eoi_any, bad, err_q;
  logic [LW-1:0] level;
  logic [DW-1:0] sel, irr_q, isr_q, imr_q;

  pic_init_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .state_o(state), .imr_we_o(imr_we), .eoi_spec_o(eoi_spec), .eoi_any_o(eoi_any),
    .level_o(level), .sel_o(sel), .base_o, .mode_o, .bad_o(bad)
  );

  pic_svc_regs #(.DW(DW)) u_svc (
    .clk_i, .rst_ni, .irq_i, .ack_i, .imr_we_i(imr_we), .wdata_i,
    .eoi_spec_i(eoi_spec), .eoi_any_i(eoi_any), .level_i(level),
    .irr_o(irr_q), .isr_o(isr_q), .imr_o(imr_q), .pend_o
  );

  pic_rdback #(.DW(DW)) u_rd (
    .addr_i, .sel_i(sel), .irr_i(irr_q), .isr_i(isr_q), .imr_i(imr_q), .rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad;
  end
  assign err_o = err_q;

  logic unused_state;
  assign unused_state = ^state;
endmodule

// File: rtl/pic_reg_core_chk.sv
module pic_reg_core_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          addr_i,
  input logic          ack_i,
  input logic [DW-1:0] irq_i,
  input logic          err_o,
  input logic          pend_o,
  input logic [DW-1:0] isr_q,
  input logic [DW-1:0] imr_q
);
  // R13
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i));

  // R5
  imr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i) |=> $stable(imr_q));

  // R12
  isr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> ((isr_q & ~$past(isr_q)) == '0));

  // R8 R9
  eoi_one_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !addr_i) |=> ($countones($past(isr_q) & ~isr_q) <= 1));

  // R7
  isr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !addr_i) |=> (($past(isr_q) & ~isr_q) == '0));

  // R11
  pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(irq_i & ~imr_q)) && !(wr_en_i && addr_i)) |=> pend_o);
endmodule

bind pic_reg_core pic_reg_core_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .ack_i(ack_i), .irq_i(irq_i), .err_o(err_o), .pend_o(pend_o),
  .isr_q(isr_q), .imr_q(imr_q)
);

// File: tb/pic_reg_core_bench.sv
`timescale 1ns/1ps
module pic_reg_core_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq = '0;
  logic [7:0] rdata, base, mode;
  logic       pend, err;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pic_reg_core u_pic_reg_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .irq_i(irq), .ack_i(ack), .rdata_o(rdata), .pend_o(pend), .err_o(err),
    .base_o(base), .mode_o(mode)
  );

  // behavioural model: 0 idle, 1..3 expecting words 2..4, 4 ready
  int         m_st = 0;
  logic [7:0] m_irr = 0, m_isr = 0, m_imr = 0, m_sel = 8'h02, m_w1 = 0, m_w2 = 0, m_w4 = 0;
  logic       m_err = 0;
  logic [7:0] pv, setb, clrb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_irr = 0; m_isr = 0; m_imr = 0; m_sel = 8'h02;
      m_w1 = 0; m_w2 = 0; m_w4 = 0; m_err = 0;
    end else begin
      m_err = 0; setb = 0; clrb = 0;
      pv = m_irr & ~m_imr;
      if (ack) for (int i = 7; i >= 0; i--) if (pv[i]) setb = 8'd1 << i;
      if (wr_en && !addr) begin
        if (wdata[4]) begin m_w1 = wdata; m_st = 1; end
        else if (m_st != 4) m_err = 1;
        else if (wdata[4:3] == 2'b01) m_sel = wdata;
        else if (wdata[5] && !wdata[7]) begin
          if (wdata[6]) clrb = 8'd1 << wdata[2:0];
          else for (int i = 7; i >= 0; i--) if (m_isr[i]) clrb = 8'd1 << i;
        end else m_err = 1;
      end else if (wr_en && addr) begin
        case (m_st)
          1: begin m_w2 = wdata; m_st = !m_w1[1] ? 2 : (m_w1[0] ? 3 : 4); end
          2: m_st = m_w1[0] ? 3 : 4;
          3: begin m_w4 = wdata; m_st = 4; end
          default: m_imr = wdata;
        endcase
      end
      m_isr = (m_isr & ~clrb) | setb;
      m_irr = (m_irr & ~setb) | irq;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic [7:0] er;
      er = addr ? m_imr : (m_sel[1:0] == 2'b10 ? m_irr : (m_sel[1:0] == 2'b11 ? m_isr : 8'h00));
      chk(addr ? "R5 rdata" : "R10 rdata", rdata, er);
      chk("R13 err", err, m_err);
      chk("R11 pend", pend, |(m_irr & ~m_imr));
      chk("R3 base", base, m_w2);
      chk("R4 mode", mode, m_w4);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic a);
    @(negedge clk); addr = a; #1;
  endtask
  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk); irq = v; @(negedge clk); irq = 0;
  endtask
  task automatic do_ack();
    @(negedge clk); ack = 1; @(negedge clk); ack = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0); chk("R1 irr read", rdata, 0);
    rd(1); chk("R1 imr read", rdata, 0);
    chk("R1 base", base, 0);
    // R6: operation word while idle
    wr(0, 8'h20); chk("R6 err idle", err, 1);
    @(negedge clk); chk("R13 err one cycle", err, 0);
    wr(1, 8'hF0); rd(1); chk("R5 imr idle", rdata, 8'hF0);
    // path: single, no word 4
    wr(0, 8'h12); wr(0, 8'h08); chk("R6 err in w2", err, 1);
    wr(1, 8'h40); chk("R3 base", base, 8'h40);
    wr(1, 8'h0F); rd(1); chk("R3 ready imr", rdata, 8'h0F);
    // path: single with word 4
    wr(0, 8'h13); wr(1, 8'h50); wr(1, 8'h03); chk("R4 mode", mode, 8'h03);
    wr(1, 8'h00); rd(1); chk("R5 imr", rdata, 0);
    // path: cascade, no word 4
    wr(0, 8'h10); wr(1, 8'h60); wr(0, 8'h20); chk("R6 err in w3", err, 1);
    wr(1, 8'h77); chk("R4 mode kept", mode, 8'h03);
    wr(1, 8'h00);
    // path: cascade with word 4
    wr(0, 8'h11); wr(1, 8'h70); wr(1, 8'h04); wr(1, 8'h05);
    chk("R4 mode path", mode, 8'h05); chk("R2 base", base, 8'h70);
    wr(1, 8'h00);
    // service and end-of-interrupt
    pulse_irq(8'h24); chk("R11 pend", pend, 1);
    do_ack(); do_ack();
    wr(0, 8'h0B); rd(0); chk("R12 isr", rdata, 8'h24);
    wr(0, 8'h0A); rd(0); chk("R12 irr cleared", rdata, 0);
    wr(0, 8'h0B);
    wr(0, 8'hA0); chk("R7 rotate err", err, 1);
    wr(0, 8'h00); chk("R7 no-eoi err", err, 1);
    rd(0); chk("R7 isr kept", rdata, 8'h24);
    wr(0, 8'h20); rd(0); chk("R9 nonspec", rdata, 8'h20);
    wr(0, 8'h65); rd(0); chk("R8 spec", rdata, 0);
    wr(0, 8'h08); rd(0); chk("R10 sel 00", rdata, 0);
    // masking
    wr(1, 8'h01); pulse_irq(8'h01); chk("R11 masked", pend, 0);
    do_ack(); wr(0, 8'h0B); rd(0); chk("R12 ack no-op", rdata, 0);
    pulse_irq(8'h02); chk("R11 unmasked", pend, 1);
    wr(0, 8'h0A); rd(0); chk("R10 irr", rdata, 8'h03);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule